// File: doc/BRIEF.md
# Split-Capable Auto-Reload Capture Timer

This block is a 16-bit timer with an 8-bit control register, a 16-bit reload register and a 16-bit count register, all reachable over a simple byte-wide register bus. It has three ways of counting. It can be one 16-bit counter that reloads on overflow. It can be two separate 8-bit counters, each reloading from its own half of the reload register. It can also be a free-running 16-bit counter whose value is copied into the reload register on a trigger edge, which is capture mode.

Each byte counts either on every system clock or on the rising edges of a selected external source. Three external sources exist: a divide-by-12 tick from the system clock, a comparator output and a divide-by-8 tick from the real-time clock. A 2-bit code in the control register picks which of them is the count source and which is the capture trigger. All three pass through a synchronizer and a rising-edge detector. Two sticky overflow flags, one for each byte, feed one interrupt request. A separate enable lets the low-byte flag take part in that request.

Top module: `split_capture_timer`

## Requirements
- R1: After reset the control register, both count bytes and both reload bytes read 0x00 and `irq` is low.
- R2: With split (control bit 3) and capture (bit 4) both clear, the 16 bits count one step per enabled tick, but only while run (bit 2) is set. An enabled tick at 0xFFFF loads the 16-bit reload value and sets the high flag (bit 7).
- R3: With split set and capture clear, the low byte counts on its ticks whatever run says. The high byte counts on its own ticks only while run is set. Each byte that passes 0xFF loads its own reload byte.
- R4: The low flag (bit 6) is set by every enabled tick that finds the low count byte at 0xFF, in any mode. Hardware never clears a flag. A bus write to the control register replaces both flags, except that a flag set by hardware in the same cycle stays set.
- R5: `irq` equals `timerIe` AND (high flag OR (low flag AND low-interrupt enable, bit 5)), combinationally.
- R6: The select code in bits 1:0 picks the count source and the trigger. 00 counts on the divide-by-12 tick and triggers on the RTC tick. 01 counts on the comparator and triggers on the RTC tick. 10 counts on the divide-by-12 tick and triggers on the comparator. 11 counts on the RTC tick and triggers on the comparator. A source that stays high for many cycles still gives exactly one event. That event takes effect on the third clock edge at which the source is sampled high.
- R7: With capture (bit 4) set, the timer counts as one 16-bit counter gated by run, whatever split says. It wraps from 0xFFFF to 0x0000 without reloading and still sets the high flag. Each trigger event copies the 16-bit count, as it was before that cycle's increment, into the reload register and sets the high flag.
- R8: `lowSelSys` and `highSelSys` choose, for the low byte and the high byte, between a tick on every clock (1) and the selected external event (0). In the 16-bit and capture modes only `lowSelSys` has an effect.
- R9: Bus addresses: 0 control, 1 reload low, 2 reload high, 3 count low, 4 count high. Reads are combinational, and any other address reads 0x00 and ignores writes. A bus write to a count byte wins over counting in the same cycle. A capture event wins over a bus write to the reload register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` |
| sysDiv12Tick | input | 1 | Divide-by-12 tick from the system clock |
| cmp0In | input | 1 | Comparator output |
| rtcDiv8Tick | input | 1 | Divide-by-8 tick from the real-time clock |
| lowSelSys | input | 1 | Low byte: 1 ticks every clock, 0 uses the external event |
| highSelSys | input | 1 | High byte: 1 ticks every clock, 0 uses the external event |
| timerIe | input | 1 | Timer interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones where events meet in one cycle. Examples are a hardware flag set that lands on the same edge as a software write that clears it, or a capture trigger that arrives together with a bus write to the reload register. Another is a 16-bit wrap at 0xFFFF that happens just as a synchronized edge gets through the three-stage pipeline. Directed sequences preload the count near 0xFFFF or 0xFF through the bus, so that these collisions come within a few cycles. A long random run then keeps toggling the sources and writing registers now and then, and a bench model predicts every register and `irq` in every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_SRC = 3;
  localparam int SRC_SYS12 = 0;
  localparam int SRC_CMP   = 1;
  localparam int SRC_RTC   = 2;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_RLD_LO = 1;
  localparam int ADDR_RLD_HI = 2;
  localparam int ADDR_CNT_LO = 3;
  localparam int ADDR_CNT_HI = 4;

  typedef struct packed {
    logic       hiFlag;
    logic       loFlag;
    logic       loIrqEn;
    logic       capEn;
    logic       splitEn;
    logic       run;
    logic [1:0] clkSel;
  } ctrl_t;

  typedef struct packed {
    logic lowEn;
    logic highEn;
    logic split;
    logic capMode;
    logic capTrig;
    logic wrCntLo;
    logic wrCntHi;
    logic wrRldLo;
    logic wrRldHi;
  } strobe_t;

  typedef struct packed {
    logic lowWrap;
    logic highWrap;
  } event_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rawIn,
  output logic [N-1:0] risePulse
);
  logic [N-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k <= STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= rawIn;
      for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign risePulse = pipe[STAGES-1] & ~pipe[STAGES];

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R6: a held level yields a single event
      a_r6_single_event: assert property (@(posedge clk) disable iff (!rstN)
        risePulse[i] |=> !risePulse[i]);
    end
  endgenerate
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [BYTE_W-1:0]    busWdata,
  input  logic [NUM_SRC-1:0]   srcRise,
  input  logic                 lowSelSys,
  input  logic                 highSelSys,
  input  logic                 timerIe,
  input  event_t               ev,
  output ctrl_t                ctrlQ,
  output strobe_t              stb,
  output logic                 irq
);
  logic  wrCtrl;
  logic  extTick;
  logic  trigTick;
  logic  tickLo;
  logic  tickHi;
  ctrl_t ctrlNext;

  assign wrCtrl = busWe && (busAddr == ADDR_W'(ADDR_CTRL));

  always_comb begin
    unique case (ctrlQ.clkSel)
      2'b00:   extTick = srcRise[SRC_SYS12];
      2'b01:   extTick = srcRise[SRC_CMP];
      2'b10:   extTick = srcRise[SRC_SYS12];
      default: extTick = srcRise[SRC_RTC];
    endcase
    trigTick = ctrlQ.clkSel[1] ? srcRise[SRC_CMP] : srcRise[SRC_RTC];
  end

  assign tickLo = lowSelSys  || extTick;
  assign tickHi = highSelSys || extTick;

  always_comb begin
    stb         = '0;
    stb.capMode = ctrlQ.capEn;
    stb.split   = ctrlQ.splitEn && !ctrlQ.capEn;
    stb.capTrig = ctrlQ.capEn && trigTick;
    stb.lowEn   = stb.split ? tickLo : (ctrlQ.run && tickLo);
    stb.highEn  = stb.split && ctrlQ.run && tickHi;
    stb.wrCntLo = busWe && (busAddr == ADDR_W'(ADDR_CNT_LO));
    stb.wrCntHi = busWe && (busAddr == ADDR_W'(ADDR_CNT_HI));
    stb.wrRldLo = busWe && (busAddr == ADDR_W'(ADDR_RLD_LO));
    stb.wrRldHi = busWe && (busAddr == ADDR_W'(ADDR_RLD_HI));
  end

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrCtrl) ctrlNext = ctrl_t'(busWdata);
    if (ev.highWrap || stb.capTrig) ctrlNext.hiFlag = 1'b1;
    if (ev.lowWrap) ctrlNext.loFlag = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  assign irq = timerIe && (ctrlQ.hiFlag || (ctrlQ.loFlag && ctrlQ.loIrqEn));

  // R2: a high wrap leaves the high flag set
  a_r2_hi_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    ev.highWrap |=> ctrlQ.hiFlag);
  // R4: flags are sticky without a control write
  a_r4_hi_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.hiFlag && !wrCtrl) |=> ctrlQ.hiFlag);
  a_r4_lo_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.loFlag && !wrCtrl) |=> ctrlQ.loFlag);
  // R5: an enabled high flag always requests
  a_r5_irq_high: assert property (@(posedge clk) disable iff (!rstN)
    (timerIe && ctrlQ.hiFlag) |-> irq);
  // R7: a capture event sets the high flag
  a_r7_cap_flag: assert property (@(posedge clk) disable iff (!rstN)
    stb.capTrig |=> ctrlQ.hiFlag);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [BYTE_W-1:0]     wdata,
  output event_t                ev,
  output logic [2*BYTE_W-1:0]   cnt,
  output logic [2*BYTE_W-1:0]   rld
);
  logic [BYTE_W-1:0] cntLo, cntHi, rldLo, rldHi;
  logic [BYTE_W-1:0] nCntLo, nCntHi, nRldLo, nRldHi;

  assign cnt = {cntHi, cntLo};
  assign rld = {rldHi, rldLo};

  always_comb begin
    ev.lowWrap = stb.lowEn && (cntLo == '1);
    if (stb.split) ev.highWrap = stb.highEn && (cntHi == '1);
    else           ev.highWrap = stb.lowEn && (cnt == '1);
  end

  always_comb begin
    nCntLo = cntLo;
    nCntHi = cntHi;
    if (stb.split) begin
      if (stb.lowEn)  nCntLo = ev.lowWrap  ? rldLo : cntLo + 1'b1;
      if (stb.highEn) nCntHi = ev.highWrap ? rldHi : cntHi + 1'b1;
    end else if (stb.lowEn) begin
      if (ev.highWrap && !stb.capMode) {nCntHi, nCntLo} = rld;
      else                             {nCntHi, nCntLo} = cnt + 1'b1;
    end
    if (stb.wrCntLo) nCntLo = wdata;
    if (stb.wrCntHi) nCntHi = wdata;

    nRldLo = rldLo;
    nRldHi = rldHi;
    if (stb.capTrig) begin
      nRldLo = cntLo;
      nRldHi = cntHi;
    end else begin
      if (stb.wrRldLo) nRldLo = wdata;
      if (stb.wrRldHi) nRldHi = wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
      rldLo <= '0;
      rldHi <= '0;
    end else begin
      cntLo <= nCntLo;
      cntHi <= nCntHi;
      rldLo <= nRldLo;
      rldHi <= nRldHi;
    end
  end

  // R2: 16-bit wrap reloads the full count
  a_r2_reload16: assert property (@(posedge clk) disable iff (!rstN)
    (ev.highWrap && !stb.split && !stb.capMode && !stb.wrCntLo && !stb.wrCntHi)
      |=> cnt == $past(rld));
  // R3: low byte advances in split mode regardless of run
  a_r3_low_free: assert property (@(posedge clk) disable iff (!rstN)
    (stb.split && stb.lowEn && !stb.wrCntLo && cntLo != '1)
      |=> cntLo == BYTE_W'($past(cntLo) + 1'b1));
  // R7: capture copies the pre-increment count
  a_r7_capture: assert property (@(posedge clk) disable iff (!rstN)
    stb.capTrig |=> rld == $past(cnt));
  // R9: bus write to a count byte wins
  a_r9_cnt_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCntLo |=> cntLo == $past(wdata));
endmodule

// File: rtl/split_capture_timer.sv
module split_capture_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              sysDiv12Tick,
  input  logic              cmp0In,
  input  logic              rtcDiv8Tick,
  input  logic              lowSelSys,
  input  logic              highSelSys,
  input  logic              timerIe,
  output logic              irq
);
  logic [NUM_SRC-1:0]   srcRaw;
  logic [NUM_SRC-1:0]   srcRise;
  ctrl_t                ctrlQ;
  strobe_t              stb;
  event_t               ev;
  logic [2*BYTE_W-1:0]  cnt;
  logic [2*BYTE_W-1:0]  rld;

  always_comb begin
    srcRaw            = '0;
    srcRaw[SRC_SYS12] = sysDiv12Tick;
    srcRaw[SRC_CMP]   = cmp0In;
    srcRaw[SRC_RTC]   = rtcDiv8Tick;
  end

  tmr_edge_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .rawIn(srcRaw), .risePulse(srcRise)
  );

  tmr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .srcRise(srcRise), .lowSelSys(lowSelSys),
    .highSelSys(highSelSys), .timerIe(timerIe), .ev(ev),
    .ctrlQ(ctrlQ), .stb(stb), .irq(irq)
  );

  tmr_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .ev(ev), .cnt(cnt), .rld(rld)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_W'(ADDR_CTRL):   busRdata = ctrlQ;
      ADDR_W'(ADDR_RLD_LO): busRdata = rld[BYTE_W-1:0];
      ADDR_W'(ADDR_RLD_HI): busRdata = rld[2*BYTE_W-1:BYTE_W];
      ADDR_W'(ADDR_CNT_LO): busRdata = cnt[BYTE_W-1:0];
      ADDR_W'(ADDR_CNT_HI): busRdata = cnt[2*BYTE_W-1:BYTE_W];
      default:              busRdata = '0;
    endcase
  end

  // R1: no request while the timer interrupt is disabled
  a_r1_irq_off: assert property (@(posedge clk) disable iff (!rstN)
    !timerIe |-> !irq);
endmodule

// File: tb/test_split_capture_timer.sv
module test_split_capture_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic sysDiv12Tick = 1'b0, cmp0In = 1'b0, rtcDiv8Tick = 1'b0;
  logic lowSelSys = 1'b1, highSelSys = 1'b1, timerIe = 1'b0;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] mCtrl = '0, mCntL = '0, mCntH = '0, mRldL = '0, mRldH = '0;
  logic [2:0] s1 = '0, s2 = '0, s3 = '0;

  always #5 clk = ~clk;

  split_capture_timer i_split_capture_timer (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sysDiv12Tick(sysDiv12Tick),
    .cmp0In(cmp0In), .rtcDiv8Tick(rtcDiv8Tick), .lowSelSys(lowSelSys),
    .highSelSys(highSelSys), .timerIe(timerIe), .irq(irq)
  );

  function automatic logic expIrq();
    return timerIe && (mCtrl[7] || (mCtrl[6] && mCtrl[5]));
  endfunction

  task automatic stepCyc();
    logic [2:0] e;
    logic ext, trig, capMode, split, run, tL, tH, lowEn, highEn, lowWrap, highWrap, capEv;
    logic [15:0] c16, r16, n16;
    logic [7:0] nL, nH, nRL, nRH, nC;
    e = s2 & ~s3;
    case (mCtrl[1:0])
      2'b00: ext = e[0];
      2'b01: ext = e[1];
      2'b10: ext = e[0];
      default: ext = e[2];
    endcase
    trig = mCtrl[1] ? e[1] : e[2];
    capMode = mCtrl[4];
    split = mCtrl[3] && !capMode;
    run = mCtrl[2];
    tL = lowSelSys || ext;
    tH = highSelSys || ext;
    lowEn = split ? tL : (run && tL);
    highEn = split && run && tH;
    c16 = {mCntH, mCntL};
    r16 = {mRldH, mRldL};
    lowWrap = lowEn && mCntL == 8'hFF;
    capEv = capMode && trig;
    nL = mCntL; nH = mCntH;
    if (split) begin
      highWrap = highEn && mCntH == 8'hFF;
      if (lowEn) nL = lowWrap ? mRldL : mCntL + 8'd1;
      if (highEn) nH = highWrap ? mRldH : mCntH + 8'd1;
    end else begin
      highWrap = lowEn && c16 == 16'hFFFF;
      n16 = c16;
      if (lowEn) n16 = (highWrap && !capMode) ? r16 : c16 + 16'd1;
      {nH, nL} = n16;
    end
    nRL = mRldL; nRH = mRldH; nC = mCtrl;
    if (busWe) begin
      case (busAddr)
        3'd0: nC = busWdata;
        3'd1: nRL = busWdata;
        3'd2: nRH = busWdata;
        3'd3: nL = busWdata;
        3'd4: nH = busWdata;
        default: ;
      endcase
    end
    if (capEv) begin nRL = mCntL; nRH = mCntH; end
    if (highWrap || capEv) nC[7] = 1'b1;
    if (lowWrap) nC[6] = 1'b1;
    s3 = s2; s2 = s1; s1 = {rtcDiv8Tick, cmp0In, sysDiv12Tick};
    @(posedge clk); #1;
    mCtrl = nC; mCntL = nL; mCntH = nH; mRldL = nRL; mRldH = nRH;
  endtask

  task automatic cmpOne(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [2:0] saveA;
    logic [7:0] expv [5];
    saveA = busAddr;
    expv[0] = mCtrl; expv[1] = mRldL; expv[2] = mRldH; expv[3] = mCntL; expv[4] = mCntH;
    for (int a = 0; a < 5; a++) begin
      busAddr = 3'(a); #0.5;
      cmpOne(tag, $sformatf("reg%0d", a), busRdata, expv[a]);
    end
    busAddr = 3'd6; #0.5;
    cmpOne(tag, "unmapped R9", busRdata, 8'h00);
    cmpOne(tag, "irq", {7'd0, irq}, {7'd0, expIrq()});
    busAddr = saveA;
  endtask

  task automatic runN(int n, string tag);
    for (int i = 0; i < n; i++) begin
      stepCyc();
      checkAll(tag);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
    busWe = 1'b1; busAddr = a; busWdata = d;
    stepCyc();
    busWe = 1'b0;
    checkAll(tag);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    checkAll("R1");

    // R9 register writes, R2 16-bit wrap with reload
    wr(3'd1, 8'h34, "R9");
    wr(3'd2, 8'h12, "R9");
    wr(3'd3, 8'hFE, "R9");
    wr(3'd4, 8'hFF, "R9");
    runN(3, "R2");                 // run clear: count holds
    wr(3'd0, 8'h04, "R2");
    runN(4, "R2");
    // R5 interrupt combinations
    timerIe = 1'b1;
    runN(1, "R5");
    wr(3'd0, 8'h44, "R5");         // low flag only, low enable clear
    wr(3'd0, 8'h64, "R5");         // low flag with low enable
    timerIe = 1'b0;
    runN(1, "R5");
    timerIe = 1'b1;
    // R4 clear collides with a low-byte wrap
    wr(3'd3, 8'hFF, "R4");
    wr(3'd0, 8'h04, "R4");
    wr(3'd0, 8'h00, "R4");
    // R3 split with run clear: low counts, high holds
    wr(3'd1, 8'hF0, "R3");
    wr(3'd3, 8'hFD, "R3");
    wr(3'd4, 8'hFE, "R3");
    wr(3'd0, 8'h08, "R3");
    runN(6, "R3");
    wr(3'd0, 8'h0C, "R3");
    runN(4, "R3");
    // R8 high byte on external divide-by-12 event
    highSelSys = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sysDiv12Tick = 1'b1; runN(4, "R8");
      sysDiv12Tick = 1'b0; runN(2, "R8");
    end
    // R6 comparator as count source, held level counts once
    lowSelSys = 1'b0;
    wr(3'd0, 8'h05, "R6");
    cmp0In = 1'b1; runN(8, "R6");
    cmp0In = 1'b0; runN(3, "R6");
    wr(3'd0, 8'h07, "R6");
    rtcDiv8Tick = 1'b1; runN(5, "R6");
    rtcDiv8Tick = 1'b0; runN(3, "R6");
    // R7 capture on comparator, collision with reload write
    lowSelSys = 1'b1;
    wr(3'd0, 8'h1E, "R7");
    cmp0In = 1'b1; runN(2, "R7");
    wr(3'd1, 8'hAA, "R7");         // capture lands this cycle
    runN(3, "R7");
    cmp0In = 1'b0; runN(2, "R7");
    wr(3'd3, 8'hFE, "R7");
    wr(3'd4, 8'hFF, "R7");
    runN(4, "R7");                 // wrap to zero without reload

    // random phase
    for (int i = 0; i < 3000; i++) begin
      busWe = ($urandom % 10) == 0;
      busAddr = 3'($urandom % 6);
      busWdata = 8'($urandom);
      if (($urandom % 3) == 0) sysDiv12Tick = ~sysDiv12Tick;
      if (($urandom % 4) == 0) cmp0In = ~cmp0In;
      if (($urandom % 5) == 0) rtcDiv8Tick = ~rtcDiv8Tick;
      if (($urandom % 40) == 0) lowSelSys = ~lowSelSys;
      if (($urandom % 40) == 0) highSelSys = ~highSelSys;
      if (($urandom % 30) == 0) timerIe = ~timerIe;
      stepCyc();
      busWe = 1'b0;
      checkAll(mCtrl[4] ? "R7" : (mCtrl[3] ? "R3" : "R2"));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule